// File: doc/BRIEF.md
# Reset Release Startup Sequencer

The sequencer keeps an internal, active-high reset asserted after the source reset is released, and again after a wake from deep sleep, until the supply and the oscillator can be assumed stable. A 3-bit startup code picks two lengths from a fixed table. The first is a supply time-out, counted in slow watchdog ticks. The second is an oscillator settle time, counted in system clocks.

After a cold start the sequence has three phases, run in this order: the supply time-out, then a fixed guard of 14 system clocks, then the oscillator settle count. A wake request skips the time-out and the guard, and runs only the settle count. When the internal reset is released, the block gives a one-cycle done pulse. The startup code is captured once, when a sequence starts, and is held for the whole sequence.

Top module: `rst_release_seq`

## Requirements
- R1: While rst_ni is low, int_rst_o is 1 and done_o is 0.
- R2: The supply time-out counts only clock cycles in which wdt_tick_i is 1. The count for each code is: 000→512, 001→8192, 011→512, 100→8192, 110→512, 111→8192, and 010 and 101→0. The edge after reset release is edge 1. With tick pulses on edges P, 2P, … (P≥2), a code with a nonzero time-out N releases int_rst_o at edge N·P+14+M.
- R3: The settle count M, in system clocks, is 258 for codes 000 and 001, 1024 for codes 010, 011 and 100, and 16384 for codes 101, 110 and 111.
- R4: A code with a zero time-out skips the tick phase, and int_rst_o falls at edge 15+M.
- R5: Between the end of the time-out and the start of settling, exactly 14 system clocks are added. These clocks do not depend on wdt_tick_i.
- R6: done_o is 1 for exactly the one cycle in which int_rst_o first reads 0 after a sequence, and is 0 otherwise.
- R7: When wake_i is 1 at edge w while the block is released, int_rst_o is 1 from edge w and falls at edge w+M. Here M is the settle count for the sel_i value at edge w, and there is no time-out or guard.
- R8: Asserting rst_ni low in the middle of a sequence restarts it. Timing is then counted from the new release, as in R2 and R4.
- R9: sel_i is sampled at edge 1 of a cold sequence, or at the wake edge. Later changes to sel_i have no effect until the next sequence.
- R10: wake_i has no effect while a sequence is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Source reset, active low, asynchronous |
| wdt_tick_i | input | 1 | One-cycle enable per watchdog oscillator cycle |
| wake_i | input | 1 | Wake from deep sleep request |
| sel_i | input | 3 | Startup code: {clock-select low bit, 2-bit startup field} |
| int_rst_o | output | 1 | Internal reset, active high |
| done_o | output | 1 | One-cycle pulse when int_rst_o is released |

## Verification
The bench runs cold starts for codes 000, 001, 010, 100, 101 and 111. This covers both time-out lengths, the zero time-out, and all three settle lengths, so an error in either table entry or in the 14-clock guard moves the release edge. Wake sequences with codes 000 and 110 show that the time-out and guard are skipped. One run has a reset in mid-sequence and checks that the count restarts. Another changes sel_i after the start, and a third pulses wake_i while a sequence is busy. These show that the captured code and the running phase are not disturbed. At every release, done_o is checked both in the release cycle and in the cycle after it.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    ST_START  = 3'd0,
    ST_TOUT   = 3'd1,
    ST_GUARD  = 3'd2,
    ST_SETTLE = 3'd3,
    ST_RUN    = 3'd4
  } rsq_state_e;
endpackage

// File: rtl/rsq_code_decode.sv
module rsq_code_decode #(
  parameter int CNT_W      = 15,
  parameter int SETTLE_S   = 258,
  parameter int SETTLE_M   = 1024,
  parameter int SETTLE_L   = 16384,
  parameter int TOUT_S     = 512,
  parameter int TOUT_L     = 8192
) (
  input  logic [2:0]       code_i,
  output logic [CNT_W-1:0] settle_len_o,
  output logic [CNT_W-1:0] tout_len_o
);
  always_comb begin
    unique case (code_i)
      3'b000, 3'b001:         settle_len_o = CNT_W'(SETTLE_S);
      3'b010, 3'b011, 3'b100: settle_len_o = CNT_W'(SETTLE_M);
      default:                settle_len_o = CNT_W'(SETTLE_L);
    endcase
    unique case (code_i)
      3'b000, 3'b011, 3'b110: tout_len_o = CNT_W'(TOUT_S);
      3'b001, 3'b100, 3'b111: tout_len_o = CNT_W'(TOUT_L);
      default:                tout_len_o = '0; // supply monitor trusted
    endcase
  end
endmodule

// File: rtl/rsq_phase_cnt.sv
module rsq_phase_cnt #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = inc_i && (cnt_q == target_i - 1'b1);

  p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |-> (cnt_q < target_i));
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
  import rsq_pkg::*;
#(
  parameter int SETTLE_S   = 258,
  parameter int SETTLE_M   = 1024,
  parameter int SETTLE_L   = 16384,
  parameter int TOUT_S     = 512,
  parameter int TOUT_L     = 8192,
  parameter int GUARD_CLKS = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wdt_tick_i,
  input  logic       wake_i,
  input  logic [2:0] sel_i,
  output logic       int_rst_o,
  output logic       done_o
);
  localparam int MAX_S = (SETTLE_L > SETTLE_M) ? ((SETTLE_L > SETTLE_S) ? SETTLE_L : SETTLE_S)
                                               : ((SETTLE_M > SETTLE_S) ? SETTLE_M : SETTLE_S);
  localparam int MAX_T = (TOUT_L > TOUT_S) ? TOUT_L : TOUT_S;
  localparam int MAX_A = (MAX_S > MAX_T) ? MAX_S : MAX_T;
  localparam int MAX_C = (MAX_A > GUARD_CLKS) ? MAX_A : GUARD_CLKS;
  localparam int CNT_W = $clog2(MAX_C + 1);

  rsq_state_e       state_q, state_d;
  logic [2:0]       sel_q, sel_use;
  logic             load, clr, inc, last;
  logic [CNT_W-1:0] target, settle_len, tout_len;
  logic             int_rst_q, done_q;

  // code is taken live only on the edge that starts a sequence
  assign load    = (state_q == ST_START) || (state_q == ST_RUN && wake_i);
  assign sel_use = load ? sel_i : sel_q;

  rsq_code_decode #(
    .CNT_W(CNT_W), .SETTLE_S(SETTLE_S), .SETTLE_M(SETTLE_M), .SETTLE_L(SETTLE_L),
    .TOUT_S(TOUT_S), .TOUT_L(TOUT_L)
  ) u_dec (
    .code_i      (sel_use),
    .settle_len_o(settle_len),
    .tout_len_o  (tout_len)
  );

  rsq_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .inc_i   (inc),
    .target_i(target),
    .last_o  (last)
  );

  always_comb begin
    state_d = state_q;
    clr     = 1'b0;
    inc     = 1'b0;
    target  = settle_len;
    unique case (state_q)
      ST_START: begin
        clr     = 1'b1;
        state_d = (tout_len == '0) ? ST_GUARD : ST_TOUT;
      end
      ST_TOUT: begin
        inc    = wdt_tick_i;
        target = tout_len;
        if (last) begin
          clr     = 1'b1;
          state_d = ST_GUARD;
        end
      end
      ST_GUARD: begin
        inc    = 1'b1;
        target = CNT_W'(GUARD_CLKS);
        if (last) begin
          clr     = 1'b1;
          state_d = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        inc = 1'b1;
        if (last) begin
          clr     = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (wake_i) begin
          clr     = 1'b1;
          state_d = ST_SETTLE;
        end
      end
      default: state_d = ST_START;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_START;
      sel_q     <= '0;
      int_rst_q <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      if (load) sel_q <= sel_i;
      int_rst_q <= (state_d != ST_RUN);
      done_q    <= (state_q != ST_RUN) && (state_d == ST_RUN);
    end
  end

  assign int_rst_o = int_rst_q;
  assign done_o    = done_q;

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_on_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_rst_o) |-> done_o);
  p_wake_settle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && wake_i) |=> (state_q == ST_SETTLE && int_rst_o));
  p_cold_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) |=> (state_q == ST_TOUT || state_q == ST_GUARD));
  p_sel_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_START && !(state_q == ST_RUN && wake_i)) |=> $stable(sel_q));
  p_busy_no_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TOUT && wake_i) |=> (state_q != ST_SETTLE || $past(last)));
endmodule

// File: tb/rst_release_seq_tb_top.sv
module rst_release_seq_tb_top;
  localparam int P = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wake = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       int_rst, done;

  int unsigned ecount;
  int          n_checks = 0, n_fail = 0, n_popped = 0;
  int          exp_q[$];
  string       tag_q[$];
  logic        prev_rst = 1'b1;
  logic        chk_done_next = 1'b0;
  string       last_tag;

  always #2 clk = ~clk;

  rst_release_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wdt_tick_i(tick), .wake_i(wake),
    .sel_i(sel), .int_rst_o(int_rst), .done_o(done)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;

  always @(negedge clk) tick <= rst_n && (((ecount + 1) % P) == 0);

  function automatic int settle_of(input logic [2:0] c);
    case (c)
      3'b000, 3'b001:         return 258;
      3'b010, 3'b011, 3'b100: return 1024;
      default:                return 16384;
    endcase
  endfunction

  function automatic int tout_of(input logic [2:0] c);
    case (c)
      3'b000, 3'b011, 3'b110: return 512;
      3'b001, 3'b100, 3'b111: return 8192;
      default:                return 0;
    endcase
  endfunction

  function automatic int cold_edge(input logic [2:0] c);
    int n;
    n = tout_of(c);
    return ((n > 0) ? n * P : 1) + 14 + settle_of(c);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop an expected release edge at each falling internal reset
  always @(negedge clk) begin
    if (chk_done_next) begin
      check(done == 1'b0, {last_tag, " R6 done after"}, done, 0);
      chk_done_next <= 1'b0;
    end
    if (rst_n && prev_rst && !int_rst) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected release", ecount, 0);
      end else begin
        last_tag = tag_q.pop_front();
        check(ecount == exp_q[0], last_tag, ecount, exp_q[0]);
        check(done == 1'b1, {last_tag, " R6 done pulse"}, done, 1);
        void'(exp_q.pop_front());
        chk_done_next <= 1'b1;
        n_popped++;
      end
    end
    if (rst_n && exp_q.size() > 0 && ecount > exp_q[0] + 4) begin
      check(1'b0, {tag_q[0], " no release"}, ecount, exp_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
      n_popped++;
    end
    prev_rst <= rst_n ? int_rst : 1'b1;
  end

  task automatic wait_pop(input int target);
    while (n_popped < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cold(input logic [2:0] c, input string tag);
    int t;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(int_rst == 1'b1, "R1 int_rst in reset", int_rst, 1);
    check(done == 1'b0, "R1 done in reset", done, 0);
    sel = c;
    rst_n = 1'b1;
    exp_q.push_back(cold_edge(c));
    tag_q.push_back(tag);
    t = n_popped + 1;
    wait_pop(t);
  endtask

  task automatic wake_seq(input logic [2:0] c, input string tag);
    int t;
    @(negedge clk);
    sel = c;
    wake = 1'b1;
    exp_q.push_back(ecount + 1 + settle_of(c));
    tag_q.push_back(tag);
    @(negedge clk);
    wake = 1'b0;
    check(int_rst == 1'b1, "R7 int_rst after wake", int_rst, 1);
    t = n_popped + 1;
    wait_pop(t);
  endtask

  initial begin
    int t;
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", ecount, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int t;
    repeat (4) @(negedge clk);
    cold(3'b000, "R2 R3 code000 short timeout");
    cold(3'b010, "R4 R5 code010 zero timeout");
    cold(3'b001, "R2 code001 long timeout");
    cold(3'b100, "R3 code100 mid settle");
    cold(3'b101, "R4 code101 long settle");
    cold(3'b111, "R2 R3 code111 longest");
    wake_seq(3'b000, "R7 wake code000");
    wake_seq(3'b110, "R7 wake code110");

    // R8: reset in mid-sequence, count restarts from new release
    @(negedge clk);
    rst_n = 1'b0;
    sel = 3'b011;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (500) @(negedge clk);
    check(int_rst == 1'b1, "R8 busy before restart", int_rst, 1);
    cold(3'b011, "R8 restart code011");

    // R9: sel changed after start
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    sel = 3'b010;
    rst_n = 1'b1;
    exp_q.push_back(cold_edge(3'b010));
    tag_q.push_back("R9 sel held");
    repeat (5) @(negedge clk);
    sel = 3'b111;
    t = n_popped + 1;
    wait_pop(t);

    // R10: wake while busy has no effect
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    sel = 3'b010;
    rst_n = 1'b1;
    exp_q.push_back(cold_edge(3'b010));
    tag_q.push_back("R10 wake ignored busy");
    repeat (200) @(negedge clk);
    sel = 3'b000;
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    t = n_popped + 1;
    wait_pop(t);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule